// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on the byte stream between an HDLC deframer and the receive FIFO and decides, packet by packet, whether the packet is stored. The deframer delivers bytes in order, and each byte carries a start marker on the first byte after the opening flag and an end marker on the last byte. The filter looks at the one or two address bytes at the head of each packet. An accepted packet is passed on unchanged. A rejected packet is consumed and nothing of it appears at the output.

Bit 0 of the first byte selects the address length. When it is 1 the address is a single byte. When it is 0 the address is two bytes. Two mask registers hold the expected address bits, and bit 0 of each mask register is that mask's enable. A global recognition enable turns filtering off entirely, and a seven-bit control widens the single-byte compare by one bit. All-call patterns override the masks. Address bytes are held in a small buffer until the verdict is known, and are then released in order ahead of the rest of the packet.

Both stream interfaces are valid/ready. A beat moves in a cycle where valid and ready are both high. While `out_ready` is low, the output beat is held stable and input intake stalls, except in three cases:
- while a packet is being dropped, where input is still drained;
- while an address is still pending, where input is still drained;
- when a new start beat arrives, which is always taken.

The buffered address bytes are sent out one per cycle. No input is taken in those cycles. After that, bytes pass straight through with no added delay. The controls `recog_en`, `mask1`, `mask2` and `seven_mode` are plain levels and should be held steady within a packet.

Top module: `hdlc_addr_filter`

## Requirements
- R1: When `recog_en` is 0, every packet is forwarded whatever its address bytes hold. This includes a packet that is only one byte long.
- R2: Bit 0 of the first byte selects the address length: 1 means one address byte and 0 means two. In one-byte mode the second byte of the packet is not compared.
- R3: In one-byte mode with mask 1 enabled, first-byte bits 7:2 must equal `mask1[7:2]`. When `seven_mode` is 1, bit 1 must also equal `mask1[1]`. `mask2` has no effect in one-byte mode.
- R4: A mask whose bit 0 is 0 is disabled, and its comparison always passes.
- R5: In one-byte mode a first byte of 0xFF is accepted even when it does not match `mask1`.
- R6: In two-byte mode, first-byte bits 7:2 must equal `mask1[7:2]` and second-byte bits 7:1 must equal `mask2[7:1]`. Each compare applies only when its mask is enabled. `seven_mode` has no effect in this mode.
- R7: In two-byte mode, a second byte whose bits 7:1 are all ones is accepted regardless of both masks.
- R8: After reset `out_valid` is 0 and `in_ready` is 1. A rejected packet produces no output beat and is drained with `in_ready` held at 1.
- R9: An accepted packet is output byte for byte in order. `out_sof` is set on its first beat and `out_eof` on its last beat. While `out_valid` is 1 and `out_ready` is 0, the output beat is held stable.
- R10: A packet that ends before its full address has arrived is discarded. A start beat always begins a new decision and discards any pending address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recog_en | input | 1 | Address recognition enable |
| mask1 | input | DW | First-byte mask; bit 0 enables it |
| mask2 | input | DW | Second-byte mask; bit 0 enables it |
| seven_mode | input | 1 | Compare bit 1 too in one-byte mode |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DW | Input byte |
| in_sof | input | 1 | First byte after opening flag |
| in_eof | input | 1 | Last byte of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | DW | Output byte |
| out_sof | output | 1 | First byte of forwarded packet |
| out_eof | output | 1 | Last byte of forwarded packet |

## Verification
The address decision and the packet end can fall in the same cycle. This happens when the byte that completes the address also carries the end marker, or when a new start beat arrives while a two-byte address is still half received. The tests provoke the first case with single-byte packets and with packets that end on their first byte. They provoke the second case by following a lone two-byte-mode first byte directly with a fresh start beat. In each case the captured output is compared byte for byte, including its start and end markers, with what the requirements predict. A separate test toggles `out_ready` during the release of the buffered address and during pass-through, to show that back-pressure does not alter or lose the released bytes.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_EMIT,
    ST_PASS,
    ST_DROP
  } af_state_t;
endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] first_in,
  input  logic [DW-1:0] first_held,
  input  logic [DW-1:0] second_in,
  input  logic [DW-1:0] mask1,
  input  logic [DW-1:0] mask2,
  input  logic          seven_mode,
  output logic          one_byte,
  output logic          verdict1,
  output logic          verdict2
);
  localparam int HI = DW - 1;

  logic m1_on, m2_on;
  logic hi_match_now, bit1_ok, all_ones_now;
  logic hi_match_held, second_match, second_all;

  always_comb begin
    m1_on         = mask1[0];
    m2_on         = mask2[0];
    one_byte      = first_in[0];
    hi_match_now  = (first_in[HI:2] == mask1[HI:2]);
    bit1_ok       = !seven_mode || (first_in[1] == mask1[1]);
    all_ones_now  = &first_in;
    verdict1      = !m1_on || all_ones_now || (hi_match_now && bit1_ok);
    hi_match_held = (first_held[HI:2] == mask1[HI:2]);
    second_match  = (second_in[HI:1] == mask2[HI:1]);
    second_all    = &second_in[HI:1];
    verdict2      = second_all ||
                    ((!m1_on || hi_match_held) && (!m2_on || second_match));
  end
endmodule

// File: rtl/hdlc_af_hold.sv
module hdlc_af_hold #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wr_last,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_last,
  output logic [DW-1:0]            head_data
);
  logic [DW-1:0] slot_data [DEPTH];
  logic          slot_last [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_data[g] <= '0;
        slot_last[g] <= 1'b0;
      end else if (wr_en && (int'(wr_idx) == g)) begin
        slot_data[g] <= wr_data;
        slot_last[g] <= wr_last;
      end
    end
  end

  always_comb begin
    rd_data   = slot_data[rd_idx];
    rd_last   = slot_last[rd_idx];
    head_data = slot_data[0];
  end
endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
  import hdlc_af_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     recog_en,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic                     out_ready,
  input  logic                     one_byte,
  input  logic                     verdict1,
  input  logic                     verdict2,
  input  logic                     rd_last,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic                     emit_active,
  output logic                     hold_wait,
  output logic [$clog2(DEPTH)-1:0] emit_idx,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_idx
);
  localparam int IW = $clog2(DEPTH);

  af_state_t         state;
  logic [IW-1:0]     last_idx;
  logic              fire;
  logic              first_accept;

  always_comb begin
    unique case (state)
      ST_EMIT: begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
      end
      ST_PASS: begin
        in_ready  = in_sof ? 1'b1 : out_ready;
        out_valid = in_valid && !in_sof;
      end
      default: begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
      end
    endcase
    fire         = in_valid && in_ready;
    first_accept = !recog_en || (one_byte && verdict1);
    emit_active  = (state == ST_EMIT);
    hold_wait    = (state == ST_HOLD);
    wr_en        = fire && (in_sof || (state == ST_HOLD));
    wr_idx       = in_sof ? IW'(0) : IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      emit_idx <= '0;
      last_idx <= '0;
    end else if (state == ST_EMIT) begin
      if (out_ready) begin
        if (emit_idx == last_idx) begin
          state <= rd_last ? ST_IDLE : ST_PASS;
        end else begin
          emit_idx <= emit_idx + IW'(1);
        end
      end
    end else if (fire) begin
      if (in_sof) begin
        emit_idx <= '0;
        if (first_accept) begin
          state    <= ST_EMIT;
          last_idx <= IW'(0);
        end else if (recog_en && !one_byte && !in_eof) begin
          state <= ST_HOLD;
        end else begin
          state <= in_eof ? ST_IDLE : ST_DROP;
        end
      end else begin
        unique case (state)
          ST_HOLD: begin
            if (verdict2) begin
              state    <= ST_EMIT;
              last_idx <= IW'(1);
            end else begin
              state <= in_eof ? ST_IDLE : ST_DROP;
            end
          end
          ST_DROP, ST_PASS: begin
            if (in_eof) state <= ST_IDLE;
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int DW         = 8,
  parameter int HOLD_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recog_en,
  input  logic [DW-1:0] mask1,
  input  logic [DW-1:0] mask2,
  input  logic          seven_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof
);
  localparam int IW = $clog2(HOLD_DEPTH);

  logic          one_byte, verdict1, verdict2;
  logic          emit_active, hold_wait;
  logic [IW-1:0] emit_idx, wr_idx;
  logic          wr_en;
  logic [DW-1:0] rd_data, head_data;
  logic          rd_last;

  hdlc_af_match #(.DW(DW)) u_match (
    .first_in   (in_data),
    .first_held (head_data),
    .second_in  (in_data),
    .mask1      (mask1),
    .mask2      (mask2),
    .seven_mode (seven_mode),
    .one_byte   (one_byte),
    .verdict1   (verdict1),
    .verdict2   (verdict2)
  );

  hdlc_af_hold #(.DW(DW), .DEPTH(HOLD_DEPTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (in_data),
    .wr_last   (in_eof),
    .rd_idx    (emit_idx),
    .rd_data   (rd_data),
    .rd_last   (rd_last),
    .head_data (head_data)
  );

  hdlc_af_ctrl #(.DEPTH(HOLD_DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .recog_en    (recog_en),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .out_ready   (out_ready),
    .one_byte    (one_byte),
    .verdict1    (verdict1),
    .verdict2    (verdict2),
    .rd_last     (rd_last),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .emit_active (emit_active),
    .hold_wait   (hold_wait),
    .emit_idx    (emit_idx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx)
  );

  always_comb begin
    out_data = emit_active ? rd_data : in_data;
    out_sof  = emit_active && (emit_idx == '0);
    out_eof  = emit_active ? rd_last : (out_valid && in_eof);
  end
endmodule

// File: rtl/hdlc_af_chk.sv
module hdlc_af_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          recog_en,
  input logic [DW-1:0] mask1,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          in_sof,
  input logic          in_eof,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sof,
  input logic          hold_wait
);
  logic in_fire;
  assign in_fire = in_valid && in_ready;

  AST_RECOG_OFF_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_sof && !recog_en) |=> (out_valid && out_sof)); // R1

  AST_SINGLE_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_sof && recog_en && in_data[0] && mask1[0] && !(&in_data) &&
     (in_data[DW-1:2] != mask1[DW-1:2])) |=> !out_valid); // R3

  AST_ALLCALL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_wait && in_fire && !in_sof && (&in_data[DW-1:1])) |=> (out_valid && out_sof)); // R7

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_RELEASE_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> !in_ready); // R9

  AST_SHORT_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_sof && in_eof && recog_en && !in_data[0]) |=> !out_valid); // R10
endmodule

bind hdlc_addr_filter hdlc_af_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .recog_en  (recog_en),
  .mask1     (mask1),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_sof    (in_sof),
  .in_eof    (in_eof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .hold_wait (hold_wait)
);

// File: tb/test_hdlc_addr_filter.sv
`timescale 1ns/100ps
module test_hdlc_addr_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       recog_en = 1'b0;
  logic [7:0] mask1 = 8'h00, mask2 = 8'h00;
  logic       seven_mode = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit bp_en = 0;
  int cyc = 0;

  logic [7:0] pkt [16];
  int         pkt_n;
  logic [7:0] cap_d [64];
  logic       cap_s [64];
  logic       cap_e [64];
  int         cap_n = 0;
  int         stalls;

  always #2.5 clk = ~clk;

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk(clk), .rst_n(rst_n), .recog_en(recog_en), .mask1(mask1), .mask2(mask2),
    .seven_mode(seven_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
  );

  // downstream ready pattern, changed just after each rising edge
  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // output monitor, samples late in the cycle
  initial forever begin
    @(posedge clk);
    #4;
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_sof;
      cap_e[cap_n] = out_eof;
      cap_n++;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic set_cfg(input logic r, input logic [7:0] m1, input logic [7:0] m2,
                         input logic s);
    recog_en = r; mask1 = m1; mask2 = m2; seven_mode = s;
  endtask

  task automatic send_bytes(input int n, input bit with_eof);
    bit ok;
    stalls = 0;
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = pkt[i];
      in_sof   = (i == 0);
      in_eof   = with_eof && (i == n - 1);
      forever begin
        #3;
        ok = in_ready;
        @(posedge clk); #1;
        if (ok) break;
        stalls++;
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #2;
  endtask

  // compares captured output against pkt[0..exp_n-1]
  task automatic compare_out(input string req, input string what, input int exp_n);
    bit bad = 0;
    checks++;
    if (cap_n != exp_n) begin
      errors++;
      $display("FAIL %s %s: beats actual %0d expected %0d", req, what, cap_n, exp_n);
      return;
    end
    for (int i = 0; i < exp_n; i++) begin
      if (cap_d[i] !== pkt[i] || cap_s[i] !== (i == 0) || cap_e[i] !== (i == exp_n - 1)) begin
        if (!bad)
          $display("FAIL %s %s: beat %0d actual %h/%b/%b expected %h/%b/%b", req, what, i,
                   cap_d[i], cap_s[i], cap_e[i], pkt[i], (i == 0), (i == exp_n - 1));
        bad = 1;
      end
    end
    if (bad) errors++;
  endtask

  task automatic run_pkt(input string req, input string what, input bit accept);
    cap_n = 0;
    send_bytes(pkt_n, 1'b1);
    settle();
    compare_out(req, what, accept ? pkt_n : 0);
  endtask

  task automatic load2(input logic [7:0] a, input logic [7:0] b);
    pkt[0] = a; pkt[1] = b; pkt[2] = 8'h5A; pkt[3] = 8'hC3; pkt_n = 4;
  endtask

  task automatic t_reset();
    #2;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R8 reset out_valid: actual %b expected 0", out_valid);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      errors++; $display("FAIL R8 reset in_ready: actual %b expected 1", in_ready);
    end
  endtask

  task automatic t_recog_off();
    set_cfg(1'b0, 8'hB1, 8'h4B, 1'b0);
    pkt[0] = 8'h70; pkt[1] = 8'h00; pkt[2] = 8'h11; pkt_n = 3;
    run_pkt("R1", "recognition off, wrong address", 1);
    pkt[0] = 8'h70; pkt_n = 1;
    run_pkt("R1", "recognition off, one-byte packet", 1);
  endtask

  task automatic t_one_byte();
    set_cfg(1'b1, 8'hB1, 8'h4B, 1'b0);
    load2(8'hB3, 8'h00);
    run_pkt("R3", "six-bit compare ignores bit 1", 1);
    run_pkt("R2", "one-byte mode leaves second byte uncompared", 1);
    seven_mode = 1'b1;
    run_pkt("R3", "seven-bit compare rejects bit 1 mismatch", 0);
    load2(8'hB1, 8'hEE);
    run_pkt("R3", "seven-bit compare match", 1);
    seven_mode = 1'b0;
    load2(8'hF3, 8'h4A);
    run_pkt("R3", "upper bits mismatch", 0);
    checks++;
    if (stalls != 0) begin
      errors++; $display("FAIL R8 reject drain stalls: actual %0d expected 0", stalls);
    end
  endtask

  task automatic t_mask_off_allcall();
    set_cfg(1'b1, 8'hB0, 8'h4B, 1'b0);
    load2(8'h13, 8'h77);
    run_pkt("R4", "mask 1 disabled, one-byte any address", 1);
    set_cfg(1'b1, 8'hB1, 8'h4A, 1'b0);
    load2(8'hB0, 8'h00);
    run_pkt("R4", "mask 2 disabled, second byte mismatch", 1);
    set_cfg(1'b1, 8'hB1, 8'h4B, 1'b0);
    load2(8'hFF, 8'h00);
    run_pkt("R5", "one-byte all-call", 1);
  endtask

  task automatic t_two_byte();
    set_cfg(1'b1, 8'hB1, 8'h4B, 1'b1);
    load2(8'hB0, 8'h4A);
    run_pkt("R6", "two-byte match, seven-bit control inert", 1);
    load2(8'hB2, 8'h00);
    run_pkt("R2", "two-byte mode compares second byte", 0);
    load2(8'hB0, 8'h4C);
    run_pkt("R6", "second byte mismatch", 0);
    load2(8'h70, 8'h4A);
    run_pkt("R6", "first byte mismatch", 0);
    load2(8'h70, 8'hFE);
    run_pkt("R7", "two-byte all-call FE", 1);
    load2(8'h70, 8'hFF);
    run_pkt("R7", "two-byte all-call FF", 1);
  endtask

  task automatic t_short_restart();
    set_cfg(1'b1, 8'hB1, 8'h4B, 1'b0);
    pkt[0] = 8'hB0; pkt_n = 1;
    run_pkt("R10", "packet ends inside address", 0);
    cap_n = 0;
    pkt[0] = 8'hB0;
    send_bytes(1, 1'b0);
    pkt[0] = 8'hB1; pkt[1] = 8'h55; pkt_n = 2;
    send_bytes(2, 1'b1);
    settle();
    compare_out("R10", "start beat restarts pending address", 2);
  endtask

  task automatic t_backpressure();
    set_cfg(1'b1, 8'hB1, 8'h4B, 1'b0);
    pkt[0] = 8'hB0; pkt[1] = 8'h4A; pkt[2] = 8'h01; pkt[3] = 8'h02;
    pkt[4] = 8'h03; pkt[5] = 8'h04; pkt_n = 6;
    bp_en = 1;
    run_pkt("R9", "order kept under back-pressure", 1);
    bp_en = 0;
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_recog_off();
    t_one_byte();
    t_mask_off_allcall();
    t_two_byte();
    t_short_restart();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule